// File: doc/BRIEF.md
# Strobed and Handshake Parallel Byte Port

This block is a byte-wide parallel port with one strobe input (STRA) and one strobe output (STRB). A small register bus gives access to a control/status register, a latched input register, an output data register and a per-bit output-enable register. An edge on STRA captures the input pins into the latched register and raises a status flag. The flag can also drive an interrupt request. Software clears the flag in two steps: it reads status while the flag is set, then it reads the latched data.

The STRB output runs in one of several modes. With handshaking off, STRB gives a fixed-length pulse on each write to the output data register. With handshaking on, a control bit picks the transfer direction and another picks pulsed or interlocked behaviour. In input direction, STRB is either a fixed-length acknowledge after each latched-data read, or a ready level that is asserted while no unread byte is pending. In output direction, a write to the latched-data address drives the pins and asserts STRB. The strobe then lasts either the pulse length or until the peer's STRA acknowledge edge. STRA is synchronized inside the block. Its idle level is taken as high during reset.

The register bus has no back-pressure. A read or write is accepted in the cycle its strobe is high. Read data is combinational from the address in the same cycle. There is no stream valid/ready pair because every transfer is paced by the STRA/STRB strobes themselves.

Top module: `ppio_port`

## Requirements
- R1: After reset, strb_o is 0, irq_o is 0, pin_oe is 0, pin_out is 0, and the control/status register (address 0) and the latched register (address 1) read 0.
- R2: The STRA edge picked by control bit 1 (0 = falling, 1 = rising) copies pin_in into the latched register (address 1) and sets status bit 7. The opposite edge changes neither the flag nor the latched data.
- R3: irq_o is high exactly when status bit 7 and control bit 6 (interrupt enable) are both 1.
- R4: Status bit 7 clears only when a read of address 0 that sees the flag set is followed by a read of address 1. A read of address 1 without that earlier status read leaves the flag set.
- R5: A second selected STRA edge before the flag is cleared overwrites the latched register, and the earlier byte is lost.
- R6: With control bit 4 = 0 (simple strobe), a write to address 2 updates pin_out and makes STRB active for exactly PULSE_LEN (2) cycles.
- R7: Control bit 0 = 1 makes STRB active-low: strb_o idles at 1 and pulses to 0.
- R8: With control bits 4,3,2 = 1,0,1 (pulsed input handshake), a read of address 1 gives a PULSE_LEN STRB pulse, and a write to address 2 gives none.
- R9: With control bits 4,3,2 = 1,0,0 (interlocked input handshake), STRB is active exactly while status bit 7 is 0.
- R10: With control bits 4,3,2 = 1,1,1 (pulsed output handshake), a write to address 1 puts the byte on pin_out and gives a PULSE_LEN STRB pulse.
- R11: With control bits 4,3,2 = 1,1,0 (interlocked output handshake), a write to address 1 puts the byte on pin_out and holds STRB active until a selected STRA edge. That edge sets the flag but does not change the latched register.
- R12: A write to address 3 sets pin_oe, and address 3 reads back the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flag sequence) |
| bus_addr | input | 2 | Register address: 0 control/status, 1 latched, 2 output, 3 enable |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| pin_in | input | DW | Parallel input pins |
| pin_out | output | DW | Parallel output data |
| pin_oe | output | DW | Per-bit output enable |
| stra_i | input | 1 | Strobe A input (asynchronous) |
| strb_o | output | 1 | Strobe B output |
| irq_o | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- the flag rises only after a detected STRA edge, and falls only in a cycle after a latched-data read;
- an interrupt rises only after an edge or a control write;
- the output enables move only after a write to their register;
- an active STRB run lasts longer than the pulse length only in an interlocked mode.

Other behaviour needs the bench's scenarios:
- that the right byte is captured and the opposite edge is ignored;
- that a data read without a prior status read leaves the flag set;
- that an overwrite loses the first byte;
- the exact pulse counts in each mode, the active-low polarity, and the release of the interlocked level on acknowledge.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LATCH = 2'd1,
    REG_OUT   = 2'd2,
    REG_DIR   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    STB_PULSE = 2'd0,
    STB_READY = 2'd1,
    STB_HOLD  = 2'd2
  } stb_mode_e;

  localparam int CB_ACT_LOW = 0;
  localparam int CB_RISE    = 1;
  localparam int CB_PULSED  = 2;
  localparam int CB_OUTDIR  = 3;
  localparam int CB_HS      = 4;
  localparam int CB_IE      = 6;
  localparam logic [6:0] CTRL_WMASK = 7'h5F;
endpackage

// File: rtl/ppio_stra_edge.sv
module ppio_stra_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stra_i,
  input  logic rise_sel,
  output logic edge_ev
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   now_s;

  assign now_s = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], stra_i};
      prev_q  <= now_s;
    end
  end

  assign edge_ev = rise_sel ? (now_s & ~prev_q) : (~now_s & prev_q);
endmodule

// File: rtl/ppio_status_flag.sv
module ppio_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic stat_rd,
  input  logic data_rd,
  output logic flag
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_ev)                  flag <= 1'b1;
      else if (data_rd && armed_q) flag <= 1'b0;

      if (data_rd)                 armed_q <= 1'b0;
      else if (stat_rd && flag)    armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ppio_strobe.sv
module ppio_strobe
  import ppio_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  stb_mode_e mode,
  input  logic      go,
  input  logic      hold_clr,
  input  logic      ready_lvl,
  input  logic      act_low,
  output logic      strb_act,
  output logic      strb_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (go && mode == STB_PULSE) cnt_q <= LOAD;
      else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;

      if (go && mode == STB_HOLD)  hold_q <= 1'b1;
      else if (hold_clr)           hold_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      STB_READY: strb_act = ready_lvl;
      STB_HOLD:  strb_act = hold_q;
      default:   strb_act = (cnt_q != '0);
    endcase
  end

  assign strb_o = strb_act ^ act_low;
endmodule

// File: rtl/ppio_port.sv
module ppio_port
  import ppio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int PULSE_LEN   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe,
  input  logic          stra_i,
  output logic          strb_o,
  output logic          irq_o
);
  logic [6:0]    ctrl_q;
  logic [DW-1:0] latch_q, out_q, dir_q;
  logic          flag_q, stra_ev, strb_act;
  logic          wr_ctrl, wr_latch, wr_out, wr_dir, rd_ctrl, rd_latch;
  logic          hs_en, out_dir, pulsed, out_hs;
  stb_mode_e     stb_mode;
  logic          stb_go;

  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
  assign wr_latch = bus_wr && (bus_addr == REG_LATCH);
  assign wr_out   = bus_wr && (bus_addr == REG_OUT);
  assign wr_dir   = bus_wr && (bus_addr == REG_DIR);
  assign rd_ctrl  = bus_rd && (bus_addr == REG_CTRL);
  assign rd_latch = bus_rd && (bus_addr == REG_LATCH);

  assign hs_en   = ctrl_q[CB_HS];
  assign out_dir = ctrl_q[CB_OUTDIR];
  assign pulsed  = ctrl_q[CB_PULSED];
  assign out_hs  = hs_en && out_dir;

  ppio_stra_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .stra_i(stra_i),
    .rise_sel(ctrl_q[CB_RISE]), .edge_ev(stra_ev)
  );

  ppio_status_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(stra_ev),
    .stat_rd(rd_ctrl), .data_rd(rd_latch), .flag(flag_q)
  );

  always_comb begin
    stb_mode = STB_PULSE;
    stb_go   = 1'b0;
    if (!hs_en) begin
      stb_go = wr_out;
    end else if (!out_dir) begin
      stb_mode = pulsed ? STB_PULSE : STB_READY;
      stb_go   = pulsed && rd_latch;
    end else begin
      stb_mode = pulsed ? STB_PULSE : STB_HOLD;
      stb_go   = wr_latch;
    end
  end

  ppio_strobe #(.PULSE_LEN(PULSE_LEN)) u_strobe (
    .clk(clk), .rst_n(rst_n), .mode(stb_mode), .go(stb_go),
    .hold_clr(stra_ev), .ready_lvl(~flag_q),
    .act_low(ctrl_q[CB_ACT_LOW]), .strb_act(strb_act), .strb_o(strb_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      latch_q <= '0;
      out_q   <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[6:0] & CTRL_WMASK;
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_out || (wr_latch && out_hs)) out_q <= bus_wdata;
      if (stra_ev && !out_hs) latch_q <= pin_in;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL:  bus_rdata[7:0] = {flag_q, ctrl_q};
      REG_LATCH: bus_rdata = latch_q;
      REG_OUT:   bus_rdata = out_q;
      default:   bus_rdata = dir_q;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_o   = flag_q && ctrl_q[CB_IE];
endmodule

// File: rtl/ppio_port_chk.sv
module ppio_port_chk #(
  parameter int DW        = 8,
  parameter int PULSE_LEN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flag_q,
  input logic          stra_ev,
  input logic          rd_latch,
  input logic          wr_ctrl,
  input logic          wr_dir,
  input logic          irq_o,
  input logic [DW-1:0] pin_oe,
  input logic          strb_act,
  input logic [6:0]    ctrl_q
);
  localparam int RW = $clog2(PULSE_LEN + 2) + 1;
  localparam logic [RW-1:0] RMAX = '1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!strb_act)         run_q <= '0;
    else if (run_q != RMAX)     run_q <= run_q + 1'b1;
  end

  a_r2_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(stra_ev));

  a_r4_flag_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(rd_latch));

  a_r3_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(stra_ev) || $past(wr_ctrl)));

  a_r12_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dir) |-> $stable(pin_oe));

  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_act && run_q >= RW'(PULSE_LEN)) |-> (ctrl_q[4] && !ctrl_q[2]));
endmodule

bind ppio_port ppio_port_chk #(.DW(DW), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .stra_ev(stra_ev),
  .rd_latch(rd_latch), .wr_ctrl(wr_ctrl), .wr_dir(wr_dir), .irq_o(irq_o),
  .pin_oe(pin_oe), .strb_act(strb_act), .ctrl_q(ctrl_q)
);

// File: tb/tb_ppio_port.sv
module tb_ppio_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic       stra_i, strb_o, irq_o;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  ppio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .stra_i(stra_i), .strb_o(strb_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_status(input logic f, input logic [7:0] c);
    return {f, c[6:0] & 7'h5F};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic drive_stra(input logic lvl);
    @(negedge clk); stra_i = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic count_strobe(input int n, input logic act_low, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (strb_o !== act_low) cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv, d, c;
    logic       e, ie, idle;
    int         n;
    void'($urandom(32'd2024));
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    pin_in = 0; stra_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 strb", strb_o, 0); check("R1 irq", irq_o, 0);
    check("R1 oe", pin_oe, 0);   check("R1 out", pin_out, 0);
    bus_read(2'd0, rv); check("R1 ctrl", rv, 0);
    bus_read(2'd1, rv); check("R1 latch", rv, 0);

    bus_write(2'd3, 8'hA5);
    check("R12 oe", pin_oe, 8'hA5);
    bus_read(2'd3, rv); check("R12 readback", rv, 8'hA5);

    // random simple-mode input capture and output strobe
    idle = 1'b1;
    for (int it = 0; it < 20; it++) begin
      e = 1'($urandom % 2); ie = 1'($urandom % 2);
      c = {1'b0, ie, 4'b0, e, 1'b0};
      bus_write(2'd0, c);
      idle = ~e; drive_stra(idle);
      d = 8'($urandom); pin_in = d;
      drive_stra(~idle);
      check("R3 irq set", irq_o, ie);
      bus_read(2'd0, rv); check("R2 flag set", rv, exp_status(1'b1, c));
      pin_in = ~d;
      drive_stra(idle);
      bus_read(2'd1, rv); check("R2 latch, opposite edge ignored", rv, d);
      bus_read(2'd0, rv); check("R4 flag cleared", rv, exp_status(1'b0, c));
      check("R3 irq clear", irq_o, 0);
      d = 8'($urandom);
      bus_write(2'd2, d);
      check("R6 pin_out", pin_out, d);
      count_strobe(6, 1'b0, n); check("R6 pulse len", n, 2);
    end

    // directed: falling edge, idle high
    bus_write(2'd0, 8'h00); drive_stra(1'b1);
    pin_in = 8'h3C; drive_stra(1'b0); drive_stra(1'b1);
    bus_read(2'd1, rv); check("R4 data", rv, 8'h3C);
    bus_read(2'd0, rv); check("R4 no clear without status read", rv, 8'h80);
    bus_read(2'd1, rv);
    bus_read(2'd0, rv); check("R4 cleared after sequence", rv, 8'h00);

    pin_in = 8'h11; drive_stra(1'b0); drive_stra(1'b1);
    pin_in = 8'h22; drive_stra(1'b0); drive_stra(1'b1);
    bus_read(2'd0, rv);
    bus_read(2'd1, rv); check("R5 overwrite", rv, 8'h22);
    bus_read(2'd0, rv); check("R5 flag clear", rv, 8'h00);

    bus_write(2'd0, 8'h01);
    check("R7 idle level", strb_o, 1);
    bus_write(2'd2, 8'h5E);
    count_strobe(6, 1'b1, n); check("R7 active-low pulse", n, 2);

    bus_write(2'd0, 8'h14);
    pin_in = 8'h5A; drive_stra(1'b0); drive_stra(1'b1);
    bus_read(2'd0, rv);
    bus_read(2'd1, rv); check("R8 data", rv, 8'h5A);
    count_strobe(6, 1'b0, n); check("R8 ack pulse", n, 2);
    bus_write(2'd2, 8'h01);
    count_strobe(6, 1'b0, n); check("R8 no pulse on out write", n, 0);

    bus_write(2'd0, 8'h10);
    @(negedge clk); check("R9 ready when empty", strb_o, 1);
    pin_in = 8'h77; drive_stra(1'b0); drive_stra(1'b1);
    check("R9 not ready when full", strb_o, 0);
    bus_read(2'd0, rv); bus_read(2'd1, rv);
    check("R9 ready after clear", strb_o, 1);

    bus_write(2'd0, 8'h1C);
    bus_write(2'd1, 8'hC3);
    check("R10 pin_out", pin_out, 8'hC3);
    count_strobe(6, 1'b0, n); check("R10 pulse", n, 2);

    bus_write(2'd0, 8'h18);
    pin_in = 8'h99;
    bus_write(2'd1, 8'h3E);
    check("R11 pin_out", pin_out, 8'h3E);
    count_strobe(10, 1'b0, n); check("R11 held", n, 10);
    drive_stra(1'b0);
    check("R11 released on ack", strb_o, 0);
    drive_stra(1'b1);
    bus_read(2'd0, rv); check("R11 flag", rv, 8'h98);
    bus_read(2'd1, rv); check("R11 latch unchanged", rv, 8'h77);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule